// File: doc/BRIEF.md
# Periodic Battery Health Tester

This block decides when a backup battery gets a load test and what the result means. After the supply has become valid and the power supervisor reports that its recovery time is over, the block runs a power-up test at once. It then repeats the test every `PERIOD_SECS` seconds, counted on a one-cycle seconds tick. During a test, `load_en` connects an external test resistor for `PULSE_SECS` seconds. A synchronized comparator flag, `batt_low`, reports whether the battery is below its trip voltage. If that flag is high in any cycle of the window, the test fails.

A failed test latches the active-low warning `warn_n`, which models an open-drain pin: 1 means released and 0 means pulled low. A passing periodic test leaves the warning in place. Only a passing power-up test or a battery-replacement pulse clears it. While the supply is invalid, all testing stops. A test cut short by supply loss gives no verdict, and the warning keeps its value.

Top module: `batt_health_tester`

## Requirements
- R1: After reset, `load_en` is 0 and `warn_n` is 1. No test starts until `supply_ok` and `recov_done` are both 1 in the same cycle; seconds ticks before that have no effect.
- R2: The power-up test starts at the first clock edge where `supply_ok` and `recov_done` are both 1, so `load_en` is 1 from that edge on. `load_en` stays 1 until the edge that samples the `PULSE_SECS`-th `sec_tick` of the window, where it returns to 0.
- R3: If `batt_low` is 1 in any cycle of the window, the test fails. This includes the cycle of the closing tick. On failure, `warn_n` goes to 0 at the same edge where `load_en` falls, and not before. `batt_low` outside a window has no effect.
- R4: A periodic test starts at the edge of the `PERIOD_SECS`-th `sec_tick` after the previous test ended. The count restarts from zero when each power-up test ends.
- R5: A passing periodic test leaves an active warning (`warn_n` = 0) unchanged.
- R6: A passing power-up test releases the warning (`warn_n` = 1) when its window closes.
- R7: While `supply_ok` is 0, `load_en` is 0 from the next edge on and `warn_n` holds its value. A test interrupted this way gives no verdict, and ticks during the outage start no test.
- R8: A `batt_swap` pulse releases the warning at the next edge. When it falls in the same cycle as a failing verdict, the release wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle pulse per elapsed second |
| supply_ok | input | 1 | Main supply within tolerance |
| recov_done | input | 1 | Supervisor recovery time has elapsed |
| batt_low | input | 1 | Synchronized comparator: battery below trip voltage |
| batt_swap | input | 1 | Pulse: battery has been replaced |
| load_en | output | 1 | Connects the test resistor while high |
| warn_n | output | 1 | Latched battery warning, active low (open-drain model) |

## Verification
A battery-replacement pulse and a failing verdict can land in the same clock cycle. Two things pull the warning in opposite directions there: the swap clears it, and the verdict tries to set it. The bench provokes this by holding `batt_low` high for a whole window and raising `batt_swap` together with the closing seconds tick. After that edge, `warn_n` must read 1. A second pair that can coincide is supply loss and a window that is still open. The bench drops `supply_ok` mid-window and expects `load_en` to fall with the warning unchanged.

// File: rtl/bht_pkg.sv
package bht_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_TEST = 2'd1,
    ST_WAIT = 2'd2
  } bht_state_e;
endpackage

// File: rtl/bht_sec_counter.sv
// Counts seconds ticks while enabled; flags the tick that completes LIMIT.
module bht_sec_counter #(
  parameter int LIMIT = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  output logic hit
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  assign hit = run && tick && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= hit ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/bht_fail_capture.sv
// Accumulates the comparator flag across one load window.
module bht_fail_capture (
  input  logic clk,
  input  logic rst,
  input  logic armed,
  input  logic close,
  input  logic low_in,
  output logic failed
);
  logic seen_q;

  assign failed = seen_q || low_in;

  always_ff @(posedge clk) begin
    if (rst || !armed || close) begin
      seen_q <= 1'b0;
    end else begin
      seen_q <= seen_q || low_in;
    end
  end
endmodule

// File: rtl/bht_warn_latch.sv
// Sticky warning; replacement beats verdict, power-up pass releases.
module bht_warn_latch (
  input  logic clk,
  input  logic rst,
  input  logic swap,
  input  logic verdict,
  input  logic failed,
  input  logic powerup,
  output logic warn_n
);
  logic warn_q;

  assign warn_n = ~warn_q;

  always_ff @(posedge clk) begin
    if (rst || swap) begin
      warn_q <= 1'b0;
    end else if (verdict) begin
      if (failed) begin
        warn_q <= 1'b1;
      end else if (powerup) begin
        warn_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/batt_health_tester.sv
module batt_health_tester #(
  parameter int PERIOD_SECS = 86400,
  parameter int PULSE_SECS  = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic sec_tick,
  input  logic supply_ok,
  input  logic recov_done,
  input  logic batt_low,
  input  logic batt_swap,
  output logic load_en,
  output logic warn_n
);
  import bht_pkg::*;

  bht_state_e st_q, st_nxt;
  logic       pu_q, pu_nxt;
  logic       win_hit, per_hit, failed, verdict, load_q;

  bht_sec_counter #(.LIMIT(PULSE_SECS)) u_window (
    .clk (clk),
    .rst (rst),
    .run (st_q == ST_TEST),
    .tick(sec_tick),
    .hit (win_hit)
  );

  bht_sec_counter #(.LIMIT(PERIOD_SECS)) u_period (
    .clk (clk),
    .rst (rst),
    .run (st_q == ST_WAIT),
    .tick(sec_tick),
    .hit (per_hit)
  );

  assign verdict = (st_q == ST_TEST) && supply_ok && win_hit;

  bht_fail_capture u_fail (
    .clk   (clk),
    .rst   (rst),
    .armed (st_q == ST_TEST),
    .close (verdict),
    .low_in(batt_low),
    .failed(failed)
  );

  bht_warn_latch u_warn (
    .clk    (clk),
    .rst    (rst),
    .swap   (batt_swap),
    .verdict(verdict),
    .failed (failed),
    .powerup(pu_q),
    .warn_n (warn_n)
  );

  always_comb begin
    st_nxt = st_q;
    pu_nxt = pu_q;
    if (!supply_ok) begin
      st_nxt = ST_OFF;
    end else begin
      case (st_q)
        ST_OFF: if (recov_done) begin
          st_nxt = ST_TEST;
          pu_nxt = 1'b1;
        end
        ST_TEST: if (win_hit) begin
          st_nxt = ST_WAIT;
          pu_nxt = 1'b0;
        end
        ST_WAIT: if (per_hit) begin
          st_nxt = ST_TEST;
          pu_nxt = 1'b0;
        end
        default: st_nxt = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_OFF;
      pu_q   <= 1'b0;
      load_q <= 1'b0;
    end else begin
      st_q   <= st_nxt;
      pu_q   <= pu_nxt;
      load_q <= (st_nxt == ST_TEST);
    end
  end

  assign load_en = load_q;
endmodule

// File: rtl/bht_checker.sv
module bht_checker (
  input logic clk,
  input logic rst,
  input logic supply_ok,
  input logic batt_swap,
  input logic load_en,
  input logic warn_n
);
  AST_LOAD_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> !load_en); // R7
  AST_START_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (rst)
    $rose(load_en) |-> $past(supply_ok)); // R2
  AST_SWAP_RELEASES: assert property (@(posedge clk) disable iff (rst)
    batt_swap |=> warn_n); // R8
  AST_WARN_SET_AT_CLOSE: assert property (@(posedge clk) disable iff (rst)
    $fell(warn_n) |-> $fell(load_en)); // R3
  AST_WARN_HELD_OFFLINE: assert property (@(posedge clk) disable iff (rst)
    (!supply_ok && !batt_swap) |=> $stable(warn_n)); // R7
  AST_WARN_RELEASE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(warn_n) |-> ($past(batt_swap) || $fell(load_en))); // R6
endmodule

bind batt_health_tester bht_checker u_bht_chk (
  .clk      (clk),
  .rst      (rst),
  .supply_ok(supply_ok),
  .batt_swap(batt_swap),
  .load_en  (load_en),
  .warn_n   (warn_n)
);

// File: tb/tb_batt_health_tester.sv
module tb_batt_health_tester;
  localparam int PER = 5;
  localparam int PUL = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sec_tick = 1'b0, supply_ok = 1'b0, recov_done = 1'b0;
  logic batt_low = 1'b0, batt_swap = 1'b0;
  logic load_en, warn_n;
  int   n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  batt_health_tester #(.PERIOD_SECS(PER), .PULSE_SECS(PUL)) dut (
    .clk(clk), .rst(rst), .sec_tick(sec_tick), .supply_ok(supply_ok),
    .recov_done(recov_done), .batt_low(batt_low), .batt_swap(batt_swap),
    .load_en(load_en), .warn_n(warn_n)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic tick(input logic swap);
    @(negedge clk);
    sec_tick = 1'b1;
    batt_swap = swap;
    @(negedge clk);
    sec_tick = 1'b0;
    batt_swap = 1'b0;
  endtask

  // Assumes a window just ended; runs the wait and checks the next start (R4).
  task automatic wait_period();
    for (int i = 0; i < PER - 1; i++) begin
      tick(1'b0);
      check("R4 no early test", load_en, 1'b0);
    end
    tick(1'b0);
    check("R4 periodic start", load_en, 1'b1);
  endtask

  // Assumes load_en just rose; runs the window, swap optional on last tick.
  task automatic run_window(input logic swap_last, input logic exp_warn_n, input string tag);
    for (int i = 0; i < PUL; i++) begin
      tick((i == PUL - 1) ? swap_last : 1'b0);
      if (i < PUL - 1) check("R2 window open", load_en, 1'b1);
    end
    check("R2 window closed", load_en, 1'b0);
    check(tag, warn_n, exp_warn_n);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1 reset load_en", load_en, 1'b0);
    check("R1 reset warn_n", warn_n, 1'b1);
    rst = 1'b0;
    supply_ok = 1'b1;
    for (int i = 0; i < 3; i++) tick(1'b0);
    check("R1 no test before recovery", load_en, 1'b0);
  endtask

  task automatic t_powerup_pass();
    @(negedge clk);
    recov_done = 1'b1;
    @(negedge clk);
    check("R2 power-up start", load_en, 1'b1);
    run_window(1'b0, 1'b1, "R6 power-up pass");
  endtask

  task automatic t_periodic_fail();
    batt_low = 1'b1;
    wait_period();
    batt_low = 1'b0;
    check("R3 low outside window ignored", warn_n, 1'b1);
    @(negedge clk); batt_low = 1'b1;
    @(negedge clk); batt_low = 1'b0;
    check("R3 no warning before close", warn_n, 1'b1);
    run_window(1'b0, 1'b0, "R3 fail latches warning");
  endtask

  task automatic t_sticky();
    wait_period();
    run_window(1'b0, 1'b0, "R5 periodic pass keeps warning");
  endtask

  task automatic t_supply_loss();
    @(negedge clk);
    supply_ok = 1'b0; recov_done = 1'b0;
    for (int i = 0; i < PER + 2; i++) tick(1'b0);
    check("R7 no test while offline", load_en, 1'b0);
    check("R7 warning held offline", warn_n, 1'b0);
    @(negedge clk);
    supply_ok = 1'b1; recov_done = 1'b1;
    @(negedge clk);
    check("R2 retest after power-up", load_en, 1'b1);
    tick(1'b0);
    @(negedge clk);
    supply_ok = 1'b0; recov_done = 1'b0;
    @(negedge clk);
    check("R7 abort drops load", load_en, 1'b0);
    check("R7 abort gives no verdict", warn_n, 1'b0);
    tick(1'b0);
    @(negedge clk);
    supply_ok = 1'b1; recov_done = 1'b1;
    @(negedge clk);
    check("R2 power-up start again", load_en, 1'b1);
    run_window(1'b0, 1'b1, "R6 power-up pass clears");
    wait_period();
    run_window(1'b0, 1'b1, "R4 schedule after restart");
  endtask

  task automatic t_swap();
    wait_period();
    batt_low = 1'b1;
    run_window(1'b0, 1'b0, "R3 held low fails");
    batt_low = 1'b0;
    @(negedge clk); batt_swap = 1'b1;
    @(negedge clk); batt_swap = 1'b0;
    check("R8 swap releases", warn_n, 1'b1);
    wait_period();
    batt_low = 1'b1;
    run_window(1'b1, 1'b1, "R8 swap beats failing verdict");
    batt_low = 1'b0;
  endtask

  initial begin
    t_reset();
    t_powerup_pass();
    t_periodic_fail();
    t_sticky();
    t_supply_loss();
    t_swap();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule